// File: doc/BRIEF.md
# Output Driver Impedance Update Sequencer

This block owns the digital code that sets the strength of a memory's output drivers. An external analog comparator reports whether the drivers are currently too weak or too strong. The block samples that direction at a fixed interval and turns it into a single-step request. It applies the request only in a cycle where the data pins are not being driven. Those cycles are writes, deselects and output-disabled cycles, which the surrounding control logic flags as a high-Z window. Because the code never changes while a read drives the bus, a driven read never sees a glitch in its output.

When a board strap says the impedance-control pin is tied to a supply rail, the drivers are forced to their strongest setting and tracking stops. A second output tells the rest of the chip when the code can be trusted. It is raised only after the part has seen a required number of non-read cycles since power-up. The code is unsigned, and a larger value means a stronger, lower-impedance driver. Across the full code range the driver spans roughly 35 to 70 ohms, which is one fifth of an external resistor of 175 to 350 ohms.

Top module: `odrv_imp_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `drv_code` becomes the mid-scale value 2^(CODE_W-1) and `cal_ok` becomes 0.
- R2: Evaluations happen on every EVAL_PERIOD-th rising edge after reset or after the strap is released (edge number EVAL_PERIOD, 2*EVAL_PERIOD, ...). At each evaluation `cmp_up` is sampled, where 1 means step the code up and 0 means step it down.
- R3: Between two consecutive clock cycles with `strap_minimp` low, `drv_code` changes by at most one.
- R4: `drv_code` changes at a rising edge only if `hiz_win` is 1 at that edge or `strap_minimp` is 1 at that edge.
- R5: An evaluation's step stays pending until the first edge with `hiz_win` = 1, where it is applied once and consumed. A newer evaluation that completes first replaces the older one. When an evaluation and an application fall on the same edge, the older request is applied and the new one is kept.
- R6: A pending up step at the all-ones code, or a down step at code 0, leaves the code unchanged.
- R7: While `strap_minimp` is 1 at an edge, `drv_code` becomes all ones, any pending step is discarded and the evaluation interval restarts.
- R8: `cal_ok` is 1 exactly when at least WARMUP_CYCLES rising edges with `rd_cycle` = 0 have occurred since reset. Edges with `rd_cycle` = 1 do not count, and once `cal_ok` is set it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_up | input | 1 | Comparator direction: 1 = strengthen (code up), 0 = weaken (code down) |
| hiz_win | input | 1 | Data outputs are high-Z in this cycle (write, deselect or output disabled) |
| rd_cycle | input | 1 | This cycle is a read cycle |
| strap_minimp | input | 1 | Impedance pin strapped to a rail: force minimum impedance |
| drv_code | output | CODE_W | Code applied to the output driver legs |
| cal_ok | output | 1 | Warm-up complete, impedance code can be trusted |

## Verification
The bench builds the block with CODE_W = 3, EVAL_PERIOD = 32 and WARMUP_CYCLES = 1024. The narrow code lets a few hundred cycles of steady comparator input drive the code into both saturation limits. The real interval keeps the 32-cycle spacing and the overwrite of stale requests visible. The full warm-up count is kept so that the exact edge where `cal_ok` rises can be checked after a long stretch in which reads and non-reads are mixed.

// File: rtl/odrv_imp_pkg.sv
// Shared types for the output impedance update sequencer.
// Assumes: nothing beyond standard SystemVerilog packed structs.
package odrv_imp_pkg;

    // A single step request waiting for a high-Z window.
    typedef struct packed {
        logic valid;   // a step is waiting
        logic up;      // 1 = strengthen (code + 1), 0 = weaken (code - 1)
    } step_req_t;

endpackage

// File: rtl/odrv_eval_timer.sv
// Evaluation interval timer.
// Produces a one-cycle tick on every PERIOD-th rising edge. While hold is
// high the count is cleared, so the interval restarts when hold drops.
// Assumes: PERIOD >= 2.
module odrv_eval_timer #(
    parameter int PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    // Tick when the final count of the interval is reached.
    always_comb tick = (cnt == LAST) && !hold;

    // Count edges within the interval, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/odrv_warmup_qual.sv
// Power-up warm-up qualifier.
// Counts rising edges at which no read is in progress and raises ready once
// LIMIT such edges have been seen. The counter saturates at LIMIT, so ready
// stays set until reset.
// Assumes: LIMIT >= 1.
module odrv_warmup_qual #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_cycle,
    output logic ready
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(LIMIT);

    logic [CNT_W-1:0] seen;

    // Ready once enough non-read edges have accumulated.
    always_comb ready = (seen == TOP);

    // Accumulate non-read edges, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (!rd_cycle && (seen != TOP)) begin
            seen <= seen + 1'b1;
        end
    end
endmodule

// File: rtl/odrv_code_stepper.sv
// Driver code register with one pending step request.
// An evaluation tick loads the comparator direction as a pending request,
// replacing any older one. The request is applied and consumed on the first
// edge with the high-Z window open. The code saturates at zero and all-ones.
// force_min pins the code to all ones and drops the request.
// Assumes: eval_tick is a single-cycle pulse.
module odrv_code_stepper
    import odrv_imp_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_min,
    input  logic              eval_tick,
    input  logic              dir_up,
    input  logic              hiz_win,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] CODE_TOP = '1;
    localparam logic [CODE_W-1:0] CODE_BOT = '0;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);

    step_req_t          pend;
    logic               apply;
    logic [CODE_W-1:0]  stepped;

    // Decide whether the waiting step lands this cycle and what it yields.
    always_comb begin
        apply = pend.valid && hiz_win;
        if (pend.up) begin
            stepped = (code == CODE_TOP) ? code : code + 1'b1;
        end else begin
            stepped = (code == CODE_BOT) ? code : code - 1'b1;
        end
    end

    // Update the code and the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= CODE_MID;
            pend <= '0;
        end else if (force_min) begin
            code <= CODE_TOP;
            pend <= '0;
        end else begin
            if (apply) begin
                code <= stepped;
            end
            if (eval_tick) begin
                pend <= '{valid: 1'b1, up: dir_up};
            end else if (apply) begin
                pend.valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/odrv_imp_seq.sv
// Output driver impedance update sequencer (top).
// Ties together the evaluation timer, the code stepper and the warm-up
// qualifier. The strap suspends tracking and forces the strongest code.
// Assumes: hiz_win and rd_cycle come from the same clock domain as clk.
module odrv_imp_seq #(
    parameter int CODE_W        = 6,
    parameter int EVAL_PERIOD   = 32,
    parameter int WARMUP_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_up,
    input  logic              hiz_win,
    input  logic              rd_cycle,
    input  logic              strap_minimp,
    output logic [CODE_W-1:0] drv_code,
    output logic              cal_ok
);
    logic eval_tick;

    odrv_eval_timer #(
        .PERIOD(EVAL_PERIOD)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (strap_minimp),
        .tick (eval_tick)
    );

    odrv_code_stepper #(
        .CODE_W(CODE_W)
    ) u_stepper (
        .clk      (clk),
        .rst_n    (rst_n),
        .force_min(strap_minimp),
        .eval_tick(eval_tick),
        .dir_up   (cmp_up),
        .hiz_win  (hiz_win),
        .code     (drv_code)
    );

    odrv_warmup_qual #(
        .LIMIT(WARMUP_CYCLES)
    ) u_warmup (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_cycle(rd_cycle),
        .ready   (cal_ok)
    );
endmodule

// File: rtl/odrv_imp_seq_chk.sv
// Assertion checker for odrv_imp_seq, attached with bind.
// Observes ports only.
module odrv_imp_seq_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hiz_win,
    input logic              rd_cycle,
    input logic              strap_minimp,
    input logic [CODE_W-1:0] drv_code,
    input logic              cal_ok
);
    localparam logic [CODE_W-1:0] CODE_TOP = '1;

    // Outside strap mode the code moves by at most one per cycle.
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_minimp |=> (drv_code == $past(drv_code)) ||
                          ({1'b0, drv_code} == {1'b0, $past(drv_code)} + 1'b1) ||
                          ({1'b0, drv_code} + 1'b1 == {1'b0, $past(drv_code)}))
        else $error("single step violated"); // R3

    // A closed window with no strap leaves the code untouched.
    AST_HIZ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!hiz_win && !strap_minimp) |=> $stable(drv_code))
        else $error("code moved outside high-Z window"); // R4

    // The strap forces the strongest code.
    AST_STRAP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        strap_minimp |=> (drv_code == CODE_TOP))
        else $error("strap did not force code"); // R7

    // Calibration flag is sticky.
    AST_CAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cal_ok |=> cal_ok)
        else $error("cal_ok dropped"); // R8

    // Calibration flag rises only on a non-read edge.
    AST_CAL_ON_NONREAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_ok) |-> !$past(rd_cycle))
        else $error("cal_ok rose on read edge"); // R8
endmodule

bind odrv_imp_seq odrv_imp_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hiz_win     (hiz_win),
    .rd_cycle    (rd_cycle),
    .strap_minimp(strap_minimp),
    .drv_code    (drv_code),
    .cal_ok      (cal_ok)
);

// File: tb/odrv_imp_seq_test.sv
// Bench for odrv_imp_seq: behavioural reference model compared every cycle,
// plus directed checks at phase boundaries.
module odrv_imp_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 3;
    localparam int PER        = 32;
    localparam int WARM       = 1024;
    localparam int CMAX       = (1 << CW) - 1;
    localparam int CMID       = 1 << (CW - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_up = 1'b0;
    logic          hiz_win = 1'b0;
    logic          rd_cycle = 1'b0;
    logic          strap_minimp = 1'b0;
    logic [CW-1:0] drv_code;
    logic          cal_ok;

    int total = 0;
    int bad = 0;
    int lfsr = 32'h1d3a;
    string phase = "R1 reset";
    bit done = 1'b0;

    // reference model state
    int m_tmr = 0;
    int m_pv = 0;
    int m_pu = 0;
    int m_code = CMID;
    int m_seen = 0;

    odrv_imp_seq #(.CODE_W(CW), .EVAL_PERIOD(PER), .WARMUP_CYCLES(WARM)) uut (
        .clk(clk), .rst_n(rst_n), .cmp_up(cmp_up), .hiz_win(hiz_win),
        .rd_cycle(rd_cycle), .strap_minimp(strap_minimp),
        .drv_code(drv_code), .cal_ok(cal_ok)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model, advanced on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tmr = 0; m_pv = 0; m_pu = 0; m_code = CMID; m_seen = 0;
        end else begin
            if (!rd_cycle && m_seen < WARM) m_seen++;
            if (strap_minimp) begin
                m_tmr = 0; m_pv = 0; m_code = CMAX;
            end else begin
                int applied;
                applied = 0;
                if (m_pv == 1 && hiz_win) begin
                    if (m_pu == 1) m_code = (m_code < CMAX) ? m_code + 1 : m_code;
                    else           m_code = (m_code > 0)    ? m_code - 1 : m_code;
                    applied = 1;
                end
                if (m_tmr == PER - 1) begin
                    m_tmr = 0; m_pv = 1; m_pu = cmp_up ? 1 : 0;
                end else begin
                    m_tmr++;
                    if (applied == 1) m_pv = 0;
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: compare outputs to the model at the falling edge, then drive.
    task automatic cyc(input bit c, input bit h, input bit r, input bit s);
        @(negedge clk);
        if (rst_n) begin
            check({phase, " drv_code"}, int'(drv_code), m_code);
            check({phase, " cal_ok (R8)"}, int'(cal_ok), (m_seen >= WARM) ? 1 : 0);
        end
        cmp_up = c; hiz_win = h; rd_cycle = r; strap_minimp = s;
    endtask

    function automatic bit rnd();
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
        return lfsr[0];
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset code", int'(drv_code), CMID);
        check("R1 reset cal_ok", int'(cal_ok), 0);

        // R4/R5: window closed, direction flips before second evaluation.
        phase = "R4 closed window";
        for (int i = 0; i < 70; i++) cyc(i < 40, 1'b0, (i % 3) != 0, 1'b0);
        check("R4 code held while closed", int'(drv_code), CMID);
        phase = "R5 pending overwrite";
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        check("R5 newest request applied", int'(drv_code), CMID - 1);

        // R2/R3/R6: steady up with window open, saturating at the top.
        phase = "R2 R3 R6 step up";
        for (int i = 0; i < 260; i++) cyc(1'b1, 1'b1, (i % 3) != 0, 1'b0);
        check("R6 saturate top", int'(drv_code), CMAX);

        // R6: steady down to the bottom.
        phase = "R2 R3 R6 step down";
        for (int i = 0; i < 300; i++) cyc(1'b0, 1'b1, (i % 3) != 0, 1'b0);
        check("R6 saturate bottom", int'(drv_code), 0);

        // R7: strap forces top code, then tracking restarts.
        phase = "R7 strap";
        for (int i = 0; i < 12; i++) cyc(1'b0, rnd(), 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        check("R7 strap forces top", int'(drv_code), CMAX);
        phase = "R7 R2 restart";
        for (int i = 0; i < 80; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
        check("R7 R2 two steps after release", int'(drv_code), CMAX - 2);

        // Mixed random traffic.
        phase = "R3 R4 R5 random";
        for (int i = 0; i < 400; i++) cyc(rnd(), rnd(), 1'b1, 1'b0);

        // R8: non-read cycles until warm-up completes.
        phase = "R8 warmup";
        for (int i = 0; i < 1100; i++) cyc(rnd(), rnd(), 1'b0, 1'b0);
        check("R8 cal_ok set", int'(cal_ok), 1);
        for (int i = 0; i < 20; i++) cyc(rnd(), rnd(), 1'b1, 1'b0);
        check("R8 cal_ok sticky", int'(cal_ok), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule